// File: doc/BRIEF.md
# Table Pointer and Latch Unit

This block moves single bytes between a byte-addressed program memory and an 8-bit data latch. A 22-bit byte pointer is built from three byte-wide registers that software loads one at a time. Bit 21 of the pointer picks the configuration/identification space instead of main program memory, and bits 20:0 reach up to 2 MB. Commands arrive already decoded, as an opcode plus a pointer-update mode. A table read asks memory for the byte at the pointer and places the returned value in the latch. A table write copies the latch into one of sixteen holding registers.

Two further commands drive a memory-programming port. A commit presents the sixteen holding bytes together with the address of the aligned 16-byte block. An erase presents the address of the aligned 64-byte block. A busy flag covers a read until its data returns and a commit or erase until the programming port acknowledges it. Every command and software write that arrives while the flag is set is dropped.

Top module: `tblu_top`

## Requirements
- R1: After reset the pointer and the latch read zero, every holding register holds 0xFF, and `busy`, `rd_req` and `pg_req` are low.
- R2: When `sw_we` is high and no command is accepted in that cycle, `sw_sel` picks the register that `sw_data` loads. 0 loads pointer bits 7:0. 1 loads bits 15:8. 2 loads bits 21:16 from `sw_data[5:0]`. 3 changes nothing. When `latch_we` is high and the unit is idle, `latch_wdata` loads the latch.
- R3: `cmd_mode` selects the pointer update for reads and writes. 0 leaves the pointer alone. 1 accesses the old pointer and then adds one. 2 accesses the old pointer and then subtracts one. 3 adds one and then accesses the new pointer. The pointer takes its new value in the cycle that follows acceptance.
- R4: The add and subtract in R3 wrap bits 20:0 modulo 2^21 and never alter bit 21.
- R5: A read (`cmd_op`=1) raises `rd_req` in the cycle after acceptance, with `rd_addr` equal to the 22-bit access address. Both hold until `rd_valid`. At the edge where `rd_valid` is seen, the latch takes `rd_data` and `busy` falls.
- R6: A write (`cmd_op`=2) copies the latch into holding register k, where k is the access address bits 3:0. The new byte shows in `pg_data[8k+7:8k]` from the next cycle, and `busy` stays low.
- R7: A commit (`cmd_op`=3) raises `pg_req` with `pg_erase` low and `pg_addr` equal to the pointer with bits 3:0 cleared. It leaves the pointer unchanged whatever the mode, and holds until `pg_ack`.
- R8: An erase (`cmd_op`=4) raises `pg_req` with `pg_erase` high and `pg_addr` equal to the pointer with bits 5:0 cleared. It holds until `pg_ack` and leaves the pointer unchanged.
- R9: While `busy` is high, commands, pointer writes and latch writes have no effect. Opcodes 0, 5, 6 and 7 are never accepted and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Pointer byte write strobe |
| sw_sel | input | 2 | Pointer byte select |
| sw_data | input | 8 | Pointer byte write data |
| latch_we | input | 1 | Latch write strobe |
| latch_wdata | input | 8 | Latch write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_mode | input | 2 | Pointer update mode |
| ptr_o | output | 22 | Current pointer |
| latch_o | output | 8 | Current latch |
| busy | output | 1 | Transfer in progress |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 22 | Memory read byte address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 8 | Read data |
| pg_req | output | 1 | Programming request |
| pg_erase | output | 1 | High for erase, low for commit |
| pg_addr | output | 22 | Aligned block byte address |
| pg_data | output | 128 | Holding bytes, byte k at bits 8k+7:8k |
| pg_ack | input | 1 | Programming acknowledge |

## Verification
The hardest situations to reach are the 21-bit wrap, with bit 21 set and clear, and colliding traffic during a pending read. To reach the wrap, the bench loads pointers at 0, 0x1FFFFF, 0x200000 and 0x3FFFFF through the byte writes and runs every update mode from each of them. To cover the collision, it holds back `rd_valid` for a few cycles on one read. During that window it sends a write command, a pointer byte write and a latch write. It then checks that the pointer, the latch and the holding bytes show no trace of them after the read completes.

// File: rtl/tblu_pkg.sv
package tblu_pkg;
    localparam int PTR_W      = 22;
    localparam int ARITH_W    = 21;
    localparam int BYTE_W     = 8;
    localparam int HOLD_N     = 16;
    localparam int HOLD_IDX_W = $clog2(HOLD_N);
    localparam int BLK_LSB    = HOLD_IDX_W;
    localparam int ERASE_LSB  = 6;
    localparam int UPPER_W    = PTR_W - 2 * BYTE_W;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_READ   = 3'd1,
        OP_WRITE  = 3'd2,
        OP_COMMIT = 3'd3,
        OP_ERASE  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        UPD_KEEP     = 2'd0,
        UPD_POST_INC = 2'd1,
        UPD_POST_DEC = 2'd2,
        UPD_PRE_INC  = 2'd3
    } upd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_PROG
    } st_e;

    typedef struct packed {
        ptr_t next;
        ptr_t access;
    } ptr_step_t;

    function automatic ptr_step_t ptr_step(ptr_t cur, upd_e mode);
        ptr_step_t r;
        logic [ARITH_W-1:0] up;
        logic [ARITH_W-1:0] dn;
        up = cur[ARITH_W-1:0] + ARITH_W'(1);
        dn = cur[ARITH_W-1:0] - ARITH_W'(1);
        r.next   = cur;
        r.access = cur;
        case (mode)
            UPD_POST_INC: r.next = {cur[PTR_W-1:ARITH_W], up};
            UPD_POST_DEC: r.next = {cur[PTR_W-1:ARITH_W], dn};
            UPD_PRE_INC: begin
                r.next   = {cur[PTR_W-1:ARITH_W], up};
                r.access = {cur[PTR_W-1:ARITH_W], up};
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic ptr_t align_down(ptr_t p, int lsb);
        return p & ~ptr_t'((1 << lsb) - 1);
    endfunction
endpackage

// File: rtl/tblu_ptr.sv
module tblu_ptr
    import tblu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              sw_en,
    input  logic [1:0]        sw_sel,
    input  logic [BYTE_W-1:0] sw_data,
    input  logic              upd_en,
    input  upd_e              upd_mode,
    output ptr_t              ptr_q,
    output ptr_t              access_addr
);
    ptr_step_t step_s;

    always_comb begin
        step_s      = ptr_step(ptr_q, upd_mode);
        access_addr = step_s.access;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (upd_en) begin
            ptr_q <= step_s.next;
        end else if (sw_en) begin
            case (sw_sel)
                2'd0: ptr_q[BYTE_W-1:0]          <= sw_data;
                2'd1: ptr_q[2*BYTE_W-1:BYTE_W]   <= sw_data;
                2'd2: ptr_q[PTR_W-1:2*BYTE_W]    <= sw_data[UPPER_W-1:0];
                default: ;
            endcase
        end
    end

    assert_space_bit_kept_R4: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> ptr_q[PTR_W-1] == $past(ptr_q[PTR_W-1]));

    assert_keep_mode_R3: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_mode == UPD_KEEP) |=> $stable(ptr_q));

    assert_busy_freezes_ptr_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ptr_q));
endmodule

// File: rtl/tblu_hold.sv
module tblu_hold
    import tblu_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [HOLD_IDX_W-1:0]    wr_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [HOLD_N*BYTE_W-1:0] bank_o
);
    logic [BYTE_W-1:0] regs [HOLD_N];

    for (genvar i = 0; i < HOLD_N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '1;
            end else if (wr_en && wr_idx == HOLD_IDX_W'(i)) begin
                regs[i] <= wr_data;
            end
        end
        assign bank_o[i*BYTE_W +: BYTE_W] = regs[i];
    end

    assert_slot_written_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/tblu_ctrl.sv
module tblu_ctrl
    import tblu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  op_e               cmd_op,
    input  ptr_t              ptr_q,
    input  ptr_t              access_addr,
    input  logic              latch_we,
    input  logic [BYTE_W-1:0] latch_wdata,
    input  logic              rd_valid,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              pg_ack,
    output logic              accept,
    output logic              upd_en,
    output logic              busy,
    output logic              hold_we,
    output logic [HOLD_IDX_W-1:0] hold_idx,
    output logic [BYTE_W-1:0] latch_q,
    output logic              rd_req,
    output ptr_t              rd_addr,
    output logic              pg_req,
    output logic              pg_erase,
    output ptr_t              pg_addr
);
    st_e  state;
    logic known_op;

    always_comb begin
        known_op = (cmd_op == OP_READ) || (cmd_op == OP_WRITE) ||
                   (cmd_op == OP_COMMIT) || (cmd_op == OP_ERASE);
        busy     = (state != ST_IDLE);
        accept   = cmd_valid && !busy && known_op;
        upd_en   = accept && (cmd_op == OP_READ || cmd_op == OP_WRITE);
        hold_we  = accept && (cmd_op == OP_WRITE);
        hold_idx = access_addr[HOLD_IDX_W-1:0];
        rd_req   = (state == ST_READ);
        pg_req   = (state == ST_PROG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            latch_q  <= '0;
            rd_addr  <= '0;
            pg_addr  <= '0;
            pg_erase <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (latch_we) latch_q <= latch_wdata;
                    if (accept) begin
                        case (cmd_op)
                            OP_READ: begin
                                state   <= ST_READ;
                                rd_addr <= access_addr;
                            end
                            OP_COMMIT: begin
                                state    <= ST_PROG;
                                pg_erase <= 1'b0;
                                pg_addr  <= align_down(ptr_q, BLK_LSB);
                            end
                            OP_ERASE: begin
                                state    <= ST_PROG;
                                pg_erase <= 1'b1;
                                pg_addr  <= align_down(ptr_q, ERASE_LSB);
                            end
                            default: ;
                        endcase
                    end
                end
                ST_READ: begin
                    if (rd_valid) begin
                        latch_q <= rd_data;
                        state   <= ST_IDLE;
                    end
                end
                ST_PROG: begin
                    if (pg_ack) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_read_req_held_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> rd_req && $stable(rd_addr));

    assert_read_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_valid) |=> !busy && latch_q == $past(rd_data));

    assert_commit_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        pg_req |-> pg_addr[BLK_LSB-1:0] == '0);

    assert_erase_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        (pg_req && pg_erase) |-> pg_addr[ERASE_LSB-1:0] == '0);

    assert_prog_held_R7: assert property (@(posedge clk) disable iff (rst)
        (pg_req && !pg_ack) |=> pg_req && $stable(pg_addr) && $stable(pg_erase));

    assert_busy_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_valid) |=> $stable(latch_q));
endmodule

// File: rtl/tblu_top.sv
module tblu_top
    import tblu_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_we,
    input  logic [1:0]   sw_sel,
    input  logic [7:0]   sw_data,
    input  logic         latch_we,
    input  logic [7:0]   latch_wdata,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_op,
    input  logic [1:0]   cmd_mode,
    output logic [21:0]  ptr_o,
    output logic [7:0]   latch_o,
    output logic         busy,
    output logic         rd_req,
    output logic [21:0]  rd_addr,
    input  logic         rd_valid,
    input  logic [7:0]   rd_data,
    output logic         pg_req,
    output logic         pg_erase,
    output logic [21:0]  pg_addr,
    output logic [127:0] pg_data,
    input  logic         pg_ack
);
    ptr_t                  ptr_q;
    ptr_t                  access_addr;
    logic                  accept;
    logic                  upd_en;
    logic                  hold_we;
    logic [HOLD_IDX_W-1:0] hold_idx;
    logic [BYTE_W-1:0]     latch_q;
    logic                  sw_en;

    assign sw_en = sw_we && !busy && !accept;

    tblu_ptr u_ptr (
        .clk         (clk),
        .rst         (rst),
        .busy        (busy),
        .sw_en       (sw_en),
        .sw_sel      (sw_sel),
        .sw_data     (sw_data),
        .upd_en      (upd_en),
        .upd_mode    (upd_e'(cmd_mode)),
        .ptr_q       (ptr_q),
        .access_addr (access_addr)
    );

    tblu_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (op_e'(cmd_op)),
        .ptr_q       (ptr_q),
        .access_addr (access_addr),
        .latch_we    (latch_we),
        .latch_wdata (latch_wdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .pg_ack      (pg_ack),
        .accept      (accept),
        .upd_en      (upd_en),
        .busy        (busy),
        .hold_we     (hold_we),
        .hold_idx    (hold_idx),
        .latch_q     (latch_q),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .pg_req      (pg_req),
        .pg_erase    (pg_erase),
        .pg_addr     (pg_addr)
    );

    tblu_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (hold_we),
        .wr_idx  (hold_idx),
        .wr_data (latch_q),
        .bank_o  (pg_data)
    );

    assign ptr_o   = ptr_q;
    assign latch_o = latch_q;
endmodule

// File: tb/sim_tblu_top.sv
module sim_tblu_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sw_we = 1'b0;
    logic [1:0]   sw_sel = '0;
    logic [7:0]   sw_data = '0;
    logic         latch_we = 1'b0;
    logic [7:0]   latch_wdata = '0;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = '0;
    logic [1:0]   cmd_mode = '0;
    logic [21:0]  ptr_o;
    logic [7:0]   latch_o;
    logic         busy;
    logic         rd_req;
    logic [21:0]  rd_addr;
    logic         rd_valid = 1'b0;
    logic [7:0]   rd_data = '0;
    logic         pg_req;
    logic         pg_erase;
    logic [21:0]  pg_addr;
    logic [127:0] pg_data;
    logic         pg_ack = 1'b0;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [21:0]  m_ptr;
    logic [7:0]   m_latch;
    logic [127:0] m_hold;

    always #4 clk = ~clk;

    tblu_top u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h3C;
    endfunction

    // expected next pointer and access address from the mode rules
    function automatic logic [21:0] exp_next(input logic [21:0] p, input int mode);
        int lo;
        lo = int'(p[20:0]);
        if (mode == 1 || mode == 3) lo = (lo + 1) % 32'h200000;
        else if (mode == 2) lo = (lo + 32'h1FFFFF) % 32'h200000;
        return {p[21], 21'(lo)};
    endfunction

    function automatic logic [21:0] exp_access(input logic [21:0] p, input int mode);
        return (mode == 3) ? exp_next(p, mode) : p;
    endfunction

    task automatic sw_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = sel; sw_data = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic set_ptr(input logic [21:0] v);
        sw_write(2'd0, v[7:0]);
        sw_write(2'd1, v[15:8]);
        sw_write(2'd2, {2'b00, v[21:16]});
        m_ptr = v;
    endtask

    task automatic set_latch(input logic [7:0] v);
        @(negedge clk);
        latch_we = 1'b1; latch_wdata = v;
        @(negedge clk);
        latch_we = 1'b0;
        m_latch = v;
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] mode);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_mode = mode;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_read(input int mode, input int lat, input bit collide);
        logic [21:0] acc;
        acc = exp_access(m_ptr, mode);
        issue(3'd1, 2'(mode));
        m_ptr = exp_next(m_ptr, mode);
        chk(rd_req == 1'b1 && busy == 1'b1, "R5 req raised", {126'd0, rd_req, busy}, 128'd3);
        chk(rd_addr == acc, "R3 R5 read address", 128'(rd_addr), 128'(acc));
        chk(ptr_o == m_ptr, "R3 R4 pointer update", 128'(ptr_o), 128'(m_ptr));
        if (collide) begin
            cmd_valid = 1'b1; cmd_op = 3'd2; cmd_mode = 2'd1;
            sw_we = 1'b1; sw_sel = 2'd0; sw_data = 8'h11;
            latch_we = 1'b1; latch_wdata = 8'h99;
            @(negedge clk);
            cmd_valid = 1'b0; sw_we = 1'b0; latch_we = 1'b0;
            chk(ptr_o == m_ptr, "R9 pointer frozen while busy", 128'(ptr_o), 128'(m_ptr));
            chk(latch_o == m_latch, "R9 latch frozen while busy", 128'(latch_o), 128'(m_latch));
            chk(pg_data == m_hold, "R9 holding frozen while busy", pg_data, m_hold);
        end
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(rd_req == 1'b1 && rd_addr == acc, "R5 req held", 128'(rd_addr), 128'(acc));
        end
        rd_valid = 1'b1; rd_data = mem_byte(acc);
        @(negedge clk);
        rd_valid = 1'b0;
        m_latch = mem_byte(acc);
        chk(latch_o == m_latch, "R5 latch captured", 128'(latch_o), 128'(m_latch));
        chk(busy == 1'b0 && rd_req == 1'b0, "R5 busy released", {126'd0, busy, rd_req}, 128'd0);
    endtask

    task automatic do_write(input int mode);
        logic [21:0] acc;
        acc = exp_access(m_ptr, mode);
        issue(3'd2, 2'(mode));
        m_ptr = exp_next(m_ptr, mode);
        m_hold[int'(acc[3:0])*8 +: 8] = m_latch;
        chk(pg_data == m_hold, "R6 holding byte", pg_data, m_hold);
        chk(busy == 1'b0, "R6 no busy", 128'(busy), 128'd0);
        chk(ptr_o == m_ptr, "R3 write pointer update", 128'(ptr_o), 128'(m_ptr));
    endtask

    task automatic do_prog(input bit erase, input int mode);
        logic [21:0] blk;
        blk = erase ? {m_ptr[21:6], 6'd0} : {m_ptr[21:4], 4'd0};
        issue(erase ? 3'd4 : 3'd3, 2'(mode));
        for (int i = 0; i < 3; i++) begin
            chk(pg_req == 1'b1 && pg_erase == erase, erase ? "R8 request" : "R7 request",
                {126'd0, pg_req, pg_erase}, {126'd0, 1'b1, erase});
            chk(pg_addr == blk, erase ? "R8 block address" : "R7 block address",
                128'(pg_addr), 128'(blk));
            chk(pg_data == m_hold, "R7 holding data", pg_data, m_hold);
            chk(ptr_o == m_ptr, "R7 R8 pointer unchanged", 128'(ptr_o), 128'(m_ptr));
            @(negedge clk);
        end
        pg_ack = 1'b1;
        @(negedge clk);
        pg_ack = 1'b0;
        chk(pg_req == 1'b0 && busy == 1'b0, "R7 R8 ack releases", {126'd0, pg_req, busy}, 128'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        logic [21:0] bases [7];
        bases = '{22'h000000, 22'h1FFFFF, 22'h200000, 22'h3FFFFF,
                  22'h00000F, 22'h1234AB, 22'h2FFFF0};
        m_ptr = '0; m_latch = '0; m_hold = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(ptr_o == 22'd0, "R1 pointer", 128'(ptr_o), 128'd0);
        chk(latch_o == 8'd0, "R1 latch", 128'(latch_o), 128'd0);
        chk(pg_data == '1, "R1 holding", pg_data, '1);
        chk(!busy && !rd_req && !pg_req, "R1 idle", {125'd0, busy, rd_req, pg_req}, 128'd0);

        // R2 byte writes
        sw_write(2'd2, 8'hFF);
        chk(ptr_o == 22'h3F0000, "R2 upper byte", 128'(ptr_o), 128'h3F0000);
        sw_write(2'd1, 8'hA5);
        chk(ptr_o == 22'h3FA500, "R2 high byte", 128'(ptr_o), 128'h3FA500);
        sw_write(2'd0, 8'h5A);
        chk(ptr_o == 22'h3FA55A, "R2 low byte", 128'(ptr_o), 128'h3FA55A);
        sw_write(2'd3, 8'h77);
        chk(ptr_o == 22'h3FA55A, "R2 select 3 ignored", 128'(ptr_o), 128'h3FA55A);
        m_ptr = 22'h3FA55A;
        set_latch(8'hC3);
        chk(latch_o == 8'hC3, "R2 latch write", 128'(latch_o), 128'hC3);

        // R9 unknown opcodes
        for (int op = 0; op < 8; op++) begin
            if (op >= 1 && op <= 4) continue;
            issue(3'(op), 2'd1);
            chk(ptr_o == m_ptr && !busy, "R9 unknown opcode", 128'(ptr_o), 128'(m_ptr));
        end

        // R3 R4 R5 read sweep over modes and boundary pointers
        for (int b = 0; b < 7; b++) begin
            for (int mode = 0; mode < 4; mode++) begin
                set_ptr(bases[b]);
                do_read(mode, (b + mode) % 3, (b == 2 && mode == 1));
            end
        end

        // R6 fill the holding bank with post-increment writes
        set_ptr(22'h2ABCD0);
        for (int i = 0; i < 16; i++) begin
            set_latch(8'h30 + 8'(i));
            do_write(1);
        end
        set_latch(8'hE7);
        do_write(3);
        set_latch(8'h5D);
        do_write(2);
        do_write(0);

        // R7 commit with a mode that must not move the pointer
        set_ptr(22'h2ABCDE);
        do_prog(1'b0, 1);
        // R8 erase
        set_ptr(22'h1FFFFF);
        do_prog(1'b1, 3);
        set_ptr(22'h3FFFC5);
        do_prog(1'b1, 0);

        report();
    end
endmodule